// File: doc/BRIEF.md
# Packed Horizontal Add/Subtract Unit

This block is a registered SIMD datapath that reduces neighbouring elements inside each of two 128-bit operands. Adjacent elements of the same operand form a pair. Each pair is either summed, or the odd element is taken from the even one. The reduced values from both operands are packed into a single 128-bit result. Elements in matching positions of the two operands are never combined with each other.

The element width can be 16 bits, which gives eight pairs across both operands, or 32 bits, which gives four pairs. With 16-bit elements, a saturating form of both operations clamps each result to the signed 16-bit range. A request is accepted on a clock edge where `valid_in` is high. The result and `valid_out` appear on the following edge. The result register holds its value until the next accepted request.

Top module: `hsimd_hadd`

## Requirements
- R1: Output element k is formed only from source elements 2k and 2k+1. The source is the 256-bit concatenation with operand A in the low half and operand B in the high half. Element 0 is the least significant element.
- R2: Results from operand A fill the low 64 bits of `result`. Results from operand B fill the high 64 bits.
- R3: `wide_sel`=0 selects eight 16-bit output elements. `wide_sel`=1 selects four 32-bit output elements.
- R4: `op_sel[0]`=1 selects subtraction, computed as the even-indexed element minus the odd-indexed element.
- R5: With `op_sel[1]`=0, sums and differences wrap modulo 2^16 or 2^32, and no overflow is indicated.
- R6: With `op_sel[1]`=1 and `wide_sel`=0, a signed result above 0x7FFF becomes 0x7FFF and a result below -0x8000 becomes 0x8000.
- R7: With `op_sel[1]`=1 and `wide_sel`=1, the result is identical to the wrapping operation.
- R8: `valid_out` equals the `valid_in` of the previous cycle. The result of a request accepted at one edge is visible after the next edge.
- R9: A synchronous active-high `rst` clears `valid_out` and `result` to zero.
- R10: When `valid_in` is low, `result` keeps its previous value whatever the operands and selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request strobe |
| op_sel | input | 2 | Bit 0: subtract; bit 1: saturate |
| wide_sel | input | 1 | 0 = 16-bit elements, 1 = 32-bit elements |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| valid_out | output | 1 | Result valid |
| result | output | 128 | Packed horizontal results |

## Verification
The bench drives each 16-bit element with its own index. A design that paired matching positions across A and B, or swapped the two halves, therefore produces results that are visibly wrong.

Saturation is driven to both limits in both directions. A clamp with the wrong sign, or a missing clamp, shows up as 0x8000 appearing where 0x7FFF belongs, or as a wrapped value. The same operands are then applied with 32-bit elements and saturation requested, which catches a design that clamps 32-bit results.

Subtraction uses asymmetric pairs to expose reversed operand order. Idle cycles with changing operands expose a result register that updates without `valid_in`.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;

    localparam int unsigned NARROW_W = 16;
    localparam int unsigned WIDE_W   = 32;

    typedef enum logic [1:0] {
        HOP_ADD  = 2'b00,
        HOP_SUB  = 2'b01,
        HOP_SADD = 2'b10,
        HOP_SSUB = 2'b11
    } hop_e;

    typedef struct packed {
        logic sub;
        logic sat;
    } hctl_t;

    // Saturation only applies to narrow elements.
    function automatic hctl_t decode_op(hop_e op, logic wide);
        hctl_t c;
        c.sub = op[0];
        c.sat = op[1] & ~wide;
        return c;
    endfunction

    function automatic logic [NARROW_W-1:0] clamp16(logic signed [NARROW_W:0] v);
        logic [NARROW_W-1:0] r;
        if (v[NARROW_W] != v[NARROW_W-1])
            r = v[NARROW_W] ? {1'b1, {(NARROW_W-1){1'b0}}} : {1'b0, {(NARROW_W-1){1'b1}}};
        else
            r = v[NARROW_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/hsimd_pair16.sv
module hsimd_pair16
    import hsimd_pkg::*;
(
    input  logic [NARROW_W-1:0] lo_i,
    input  logic [NARROW_W-1:0] hi_i,
    input  logic                sub_i,
    input  logic                sat_i,
    output logic [NARROW_W-1:0] res_o
);
    logic signed [NARROW_W:0] ext_lo, ext_hi, raw;

    always_comb begin
        ext_lo = {lo_i[NARROW_W-1], lo_i};
        ext_hi = {hi_i[NARROW_W-1], hi_i};
        raw    = sub_i ? (ext_lo - ext_hi) : (ext_lo + ext_hi);
        res_o  = sat_i ? clamp16(raw) : raw[NARROW_W-1:0];
    end

    // Two non-negative inputs added with saturation never give a negative result.
    always_comb begin
        if (sat_i && !sub_i && !lo_i[NARROW_W-1] && !hi_i[NARROW_W-1])
            AST_SAT_POS_ADD: assert (!res_o[NARROW_W-1]); // R6
        if (sat_i && !sub_i && lo_i[NARROW_W-1] && hi_i[NARROW_W-1])
            AST_SAT_NEG_ADD: assert (res_o[NARROW_W-1]); // R6
    end
endmodule

// File: rtl/hsimd_pair32.sv
module hsimd_pair32
    import hsimd_pkg::*;
(
    input  logic [WIDE_W-1:0] lo_i,
    input  logic [WIDE_W-1:0] hi_i,
    input  logic              sub_i,
    output logic [WIDE_W-1:0] res_o
);
    always_comb res_o = sub_i ? (lo_i - hi_i) : (lo_i + hi_i);

    // A zero odd element leaves the even element unchanged in both operations.
    always_comb begin
        if (hi_i == '0)
            AST_WIDE_IDENTITY: assert (res_o == lo_i); // R5
    end
endmodule

// File: rtl/hsimd_hadd.sv
module hsimd_hadd
    import hsimd_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [1:0]       op_sel,
    input  logic             wide_sel,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             valid_out,
    output logic [VEC_W-1:0] result
);
    localparam int unsigned N_NARROW = VEC_W / NARROW_W;
    localparam int unsigned N_WIDE   = VEC_W / WIDE_W;

    hctl_t               ctl;
    logic [2*VEC_W-1:0]  src;
    logic [VEC_W-1:0]    res_n, res_w, res_next;

    always_comb begin
        ctl = decode_op(hop_e'(op_sel), wide_sel);
        src = {opnd_b, opnd_a};
    end

    for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
        hsimd_pair16 u_pair (
            .lo_i  (src[2*k*NARROW_W +: NARROW_W]),
            .hi_i  (src[(2*k+1)*NARROW_W +: NARROW_W]),
            .sub_i (ctl.sub),
            .sat_i (ctl.sat),
            .res_o (res_n[k*NARROW_W +: NARROW_W])
        );
    end

    for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
        hsimd_pair32 u_pair (
            .lo_i  (src[2*k*WIDE_W +: WIDE_W]),
            .hi_i  (src[(2*k+1)*WIDE_W +: WIDE_W]),
            .sub_i (ctl.sub),
            .res_o (res_w[k*WIDE_W +: WIDE_W])
        );
    end

    always_comb res_next = wide_sel ? res_w : res_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in)
                result <= res_next;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out); // R8
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result)); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!valid_out && result == '0)); // R9
endmodule

// File: tb/test_hsimd_hadd.sv
module test_hsimd_hadd;
    logic         clk = 1'b0;
    logic         rst;
    logic         valid_in;
    logic [1:0]   op_sel;
    logic         wide_sel;
    logic [127:0] opnd_a, opnd_b;
    logic         valid_out;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res = '0;

    always #2 clk = ~clk;

    hsimd_hadd i_hsimd_hadd (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
        .wide_sel(wide_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .valid_out(valid_out), .result(result)
    );

    function automatic longint elem(input logic [127:0] a, input logic [127:0] b,
                                    input int idx, input int w);
        int per = 128 / w;
        logic [31:0] raw;
        if (idx < per) raw = (w == 16) ? {16'h0, a[idx*16 +: 16]} : a[idx*32 +: 32];
        else           raw = (w == 16) ? {16'h0, b[(idx-per)*16 +: 16]} : b[(idx-per)*32 +: 32];
        if (w == 16) return longint'($signed(raw[15:0]));
        return longint'($signed(raw));
    endfunction

    function automatic logic [127:0] model(input logic [1:0] op, input logic wide,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        int w = wide ? 32 : 16;
        for (int k = 0; k < 128 / w; k++) begin
            longint x = elem(a, b, 2*k, w);
            longint y = elem(a, b, 2*k+1, w);
            longint s = op[0] ? x - y : x + y;
            if (op[1] && !wide) begin
                if (s > 32767) s = 32767;
                if (s < -32768) s = -32768;
            end
            if (wide) r[k*32 +: 32] = s[31:0];
            else      r[k*16 +: 16] = s[15:0];
        end
        return r;
    endfunction

    task automatic step(input logic r, input logic v, input logic [1:0] op, input logic wide,
                        input logic [127:0] a, input logic [127:0] b, input string tag);
        logic exp_v;
        @(negedge clk);
        rst = r; valid_in = v; op_sel = op; wide_sel = wide; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
        if (r) begin exp_res = '0; exp_v = 1'b0; end
        else begin
            exp_v = v;
            if (v) exp_res = model(op, wide, a, b);
        end
        checks++;
        if (valid_out !== exp_v || result !== exp_res) begin
            errors++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     tag, valid_out, result, exp_v, exp_res);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] idx_a, idx_b;
        for (int i = 0; i < 8; i++) begin
            idx_a[i*16 +: 16] = 16'(i);
            idx_b[i*16 +: 16] = 16'(i + 8);
        end
        rst = 1'b1; valid_in = 1'b0; op_sel = 2'b00; wide_sel = 1'b0;
        opnd_a = '0; opnd_b = '0;
        step(1, 1, 2'b00, 0, idx_a, idx_b, "R9 reset state");
        step(1, 0, 2'b00, 0, '0, '0, "R9 reset held");
        // R1 R2 R3: index pattern, narrow and wide
        step(0, 1, 2'b00, 0, idx_a, idx_b, "R1 R2 narrow pairing");
        step(0, 1, 2'b00, 1, idx_a, idx_b, "R3 wide pairing");
        // R4: even minus odd
        step(0, 1, 2'b01, 0, idx_a, idx_b, "R4 narrow subtract order");
        step(0, 1, 2'b01, 1, {4{32'h0000_0001, 32'h0000_0064}}, {4{32'h0000_0003, 32'h0000_0010}},
             "R4 wide subtract order");
        // R5: wrapping
        step(0, 1, 2'b00, 0, {8{16'h7FFF, 16'h0001}}, {8{16'h8000, 16'hFFFF}}, "R5 narrow add wraps");
        step(0, 1, 2'b01, 0, {8{16'h0001, 16'h8000}}, {8{16'hFFFF, 16'h7FFF}}, "R5 narrow sub wraps");
        step(0, 1, 2'b00, 1, {2{32'h7FFF_FFFF, 32'h0000_0001}}, {2{32'hFFFF_FFFF, 32'h8000_0000}},
             "R5 wide add wraps");
        // R6: saturation at both limits, add and subtract
        step(0, 1, 2'b10, 0, {8{16'h7FFF, 16'h0001}}, {8{16'h8000, 16'hFFFF}}, "R6 sat add clamps");
        step(0, 1, 2'b11, 0, {8{16'h0001, 16'h8000}}, {8{16'hFFFF, 16'h7FFF}}, "R6 sat sub clamps");
        step(0, 1, 2'b10, 0, {8{16'h4000, 16'h3FFF}}, {8{16'hC000, 16'hC000}}, "R6 sat add at limits");
        // R7: saturation request with wide elements wraps
        step(0, 1, 2'b10, 1, {2{32'h7FFF_FFFF, 32'h0000_0001}}, {2{32'hFFFF_FFFF, 32'h8000_0000}},
             "R7 wide sat add wraps");
        step(0, 1, 2'b11, 1, {2{32'h0000_0001, 32'h8000_0000}}, {2{32'h7FFF_FFFF, 32'hFFFF_FFFF}},
             "R7 wide sat sub wraps");
        // R10: idle with changing inputs keeps result
        step(0, 0, 2'b01, 0, idx_b, idx_a, "R10 hold idle");
        step(0, 0, 2'b11, 1, '1, '0, "R10 hold idle changed");
        // R8: back-to-back and random traffic
        for (int n = 0; n < 300; n++) begin
            logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
            step(0, 1'($urandom % 4 != 0), 2'($urandom), 1'($urandom), ra, rb, "R8 random stream");
        end
        step(1, 1, 2'b00, 0, idx_a, idx_b, "R9 reset after traffic");
        step(0, 0, 2'b00, 0, idx_a, idx_b, "R10 idle after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule